// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Timer with Fault Restart

This block paces the power switch of a primary-side controlled quasi-resonant converter stage. It raises the gate, ends the conduction interval when the current-sense comparator reports that the peak target is reached, and then times how long the magnetic element takes to discharge, using a zero-crossing flag from an auxiliary winding. The next conduction interval starts in a valley, at the first zero crossing after discharge has finished and the period requested by the regulation logic has passed. A maximum-period timeout ends the wait when no valley arrives.

Bounds on conduction time and switching period are enforced in clock cycles. Blanking windows mask the sense comparators just after each gate edge. Three protections shut the gate off and hold it off for a fixed restart interval: sense current above the overcurrent level, the sense signal never reaching its low level during a conduction interval (open loop or shorted sense resistor), and auxiliary overvoltage (open output). At each normal cycle end the measured conduction and discharge counts are presented with a one-cycle strobe.

Top module: `qr_gate_ctrl`

## Requirements
- R1: While reset is high, gate_o, cyc_vld_o and flt_o are 0; the gate goes high at the first clock edge after reset falls.
- R2: The gate goes low after the first on-cycle t (the first gate-high cycle is t=1) for which pk_i is 1, t is larger than LEB_CYC and t is at least TON_MIN_CYC; pk_i and ocp_i are ignored while t is at most LEB_CYC.
- R3: On-time never exceeds the ceiling, which is TON_MAX_FLY when BUCK=0 and TON_MAX_BUCK when BUCK=1; reaching the ceiling ends the on-time.
- R4: Discharge time counts gate-low cycles from d=1 after the gate falls; zcd_i is ignored while d is at most the blanking length (ZBLK_LV when HV=0, ZBLK_HV when HV=1); tdm_o is the first unblanked d with zcd_i high, or d when the period reaches PER_MAX_CYC first.
- R5: The period count p starts at 1 on the first gate-high cycle; the gate rises again after the first cycle where discharge is done, zcd_i is high and p is at least the target clamped into [PER_MIN_CYC, PER_MAX_CYC], or after the cycle where p reaches PER_MAX_CYC; rise to rise spacing equals that p.
- R6: ocp_i high at an unblanked on-cycle drives the gate low at the next edge and sets flt_o to 2.
- R7: If the on-time ends at the ceiling without olp_lvl_i or pk_i having been high on any unblanked on-cycle, the gate goes low and flt_o becomes 3.
- R8: ovp_i high at an unblanked discharge cycle (same blanking as R4) sets flt_o to 1; the gate stays low.
- R9: After any fault the gate stays low for exactly RESTART_CYC cycles counted from the fault edge, flt_o keeps its code during that time, and then the gate rises with flt_o back at 0 and no cyc_vld_o pulse.
- R10: cyc_vld_o is a one-cycle pulse that coincides with each gate rise that ends a normal cycle; ton_o and tdm_o then hold the on-time and discharge time of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tgt_per_i | input | CNT_W | Requested switching period in cycles |
| pk_i | input | 1 | Sense current has reached the peak target |
| ocp_i | input | 1 | Sense current above the overcurrent level |
| olp_lvl_i | input | 1 | Sense signal above its low open-loop level |
| ovp_i | input | 1 | Auxiliary winding above the overvoltage level |
| zcd_i | input | 1 | Auxiliary winding zero crossing (valley) |
| gate_o | output | 1 | Power switch gate command |
| ton_o | output | CNT_W | Last measured on-time in cycles |
| tdm_o | output | CNT_W | Last measured discharge time in cycles |
| cyc_vld_o | output | 1 | Strobe for a completed normal cycle |
| flt_o | output | 2 | Fault code: 0 none, 1 overvoltage, 2 overcurrent, 3 open loop |

## Verification
Every cycle, the assertions hold the on-time between its floor and ceiling at each normal gate fall, keep blanking in force at that fall, keep every strobed period inside the allowed window, keep the gate low while a fault code is shown, tie the strobe to a gate rise and bound the restart and discharge counters. Only the bench scenarios show that the exact cycle of each gate edge follows the peak arrival, valley timing and target period, that each protection produces its own code, and that the restart gap has the exact length.

// File: rtl/qrg_pkg.sv
package qrg_pkg;
   typedef enum logic [2:0] {
      ST_START,
      ST_ON,
      ST_DEMAG,
      ST_WAIT,
      ST_FAULT
   } qrg_state_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_OVP  = 2'd1,
      FLT_OCP  = 2'd2,
      FLT_OLP  = 2'd3
   } qrg_flt_e;
endpackage

// File: rtl/qrg_on_timer.sv
module qrg_on_timer #(
   parameter int CW           = 17,
   parameter int LEB_CYC      = 28,
   parameter int TON_MIN_CYC  = 28,
   parameter int TON_MAX_FLY  = 440,
   parameter int TON_MAX_BUCK = 600,
   parameter bit BUCK         = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          act_i,
   input  logic          pk_i,
   input  logic          ocp_i,
   input  logic          lvl_i,
   output logic [CW-1:0] t_o,
   output logic          end_o,
   output logic          ocp_flt_o,
   output logic          olp_flt_o
);
   localparam logic [CW-1:0] LEB_C  = CW'(LEB_CYC);
   localparam logic [CW-1:0] TMIN_C = CW'(TON_MIN_CYC);

   logic [CW-1:0] tmax;
   logic [CW-1:0] t_q;
   logic          seen_q;
   logic          unbl;
   logic          end_pk;
   logic          end_max;
   logic          seen_now;

   generate
      if (BUCK) begin : g_buck
         assign tmax = CW'(TON_MAX_BUCK);
      end else begin : g_fly
         assign tmax = CW'(TON_MAX_FLY);
      end
   endgenerate

   assign t_o      = t_q + CW'(1);
   assign unbl     = t_o > LEB_C;
   assign end_pk   = act_i && unbl && (t_o >= TMIN_C) && pk_i;
   assign end_max  = act_i && (t_o >= tmax);
   assign seen_now = seen_q || (unbl && (lvl_i || pk_i));
   assign end_o     = end_pk || end_max;
   assign ocp_flt_o = act_i && unbl && ocp_i;
   assign olp_flt_o = end_max && !end_pk && !seen_now;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         t_q    <= '0;
         seen_q <= 1'b0;
      end else if (act_i) begin
         t_q    <= t_o;
         seen_q <= seen_now;
      end else begin
         t_q    <= '0;
         seen_q <= 1'b0;
      end
   end

   AST_TON_CEILING: assert property (@(posedge clk_i) disable iff (rst_i)
      act_i |-> t_o <= tmax); // R3
endmodule

// File: rtl/qrg_demag_timer.sv
module qrg_demag_timer #(
   parameter int CW      = 17,
   parameter int ZBLK_LV = 100,
   parameter int ZBLK_HV = 140,
   parameter bit HV      = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          act_i,
   input  logic          zcd_i,
   input  logic          ovp_i,
   output logic [CW-1:0] d_o,
   output logic          zc_o,
   output logic          ovp_flt_o
);
   logic [CW-1:0] zblk;
   logic [CW-1:0] d_q;
   logic          unbl;

   generate
      if (HV) begin : g_hv
         assign zblk = CW'(ZBLK_HV);
      end else begin : g_lv
         assign zblk = CW'(ZBLK_LV);
      end
   endgenerate

   assign d_o       = d_q + CW'(1);
   assign unbl      = d_o > zblk;
   assign ovp_flt_o = act_i && unbl && ovp_i;
   assign zc_o      = act_i && unbl && zcd_i && !ovp_i;

   always_ff @(posedge clk_i) begin
      if (rst_i)      d_q <= '0;
      else if (act_i) d_q <= d_o;
      else            d_q <= '0;
   end

   AST_DEMAG_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      act_i && $past(act_i) |-> d_o == $past(d_o) + CW'(1)); // R4
endmodule

// File: rtl/qrg_restart_tmr.sv
module qrg_restart_tmr #(
   parameter int RESTART_CYC = 50_000_000
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic act_i,
   output logic done_o
);
   localparam int RW = $clog2(RESTART_CYC + 1);
   localparam logic [RW-1:0] LIM_C = RW'(RESTART_CYC);

   logic [RW-1:0] r_q;
   logic [RW-1:0] r_nx;

   assign r_nx   = r_q + RW'(1);
   assign done_o = act_i && (r_nx >= LIM_C);

   always_ff @(posedge clk_i) begin
      if (rst_i)      r_q <= '0;
      else if (act_i) r_q <= r_nx;
      else            r_q <= '0;
   end

   AST_RESTART_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
      r_q <= LIM_C); // R9
endmodule

// File: rtl/qr_gate_ctrl.sv
module qr_gate_ctrl
   import qrg_pkg::*;
#(
   parameter int CNT_W        = 17,
   parameter int LEB_CYC      = 28,
   parameter int TON_MIN_CYC  = 28,
   parameter int TON_MAX_FLY  = 440,
   parameter int TON_MAX_BUCK = 600,
   parameter int PER_MIN_CYC  = 250,
   parameter int PER_MAX_CYC  = 80000,
   parameter int ZBLK_LV      = 100,
   parameter int ZBLK_HV      = 140,
   parameter int RESTART_CYC  = 50_000_000,
   parameter bit BUCK         = 1'b0,
   parameter bit HV           = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] tgt_per_i,
   input  logic             pk_i,
   input  logic             ocp_i,
   input  logic             olp_lvl_i,
   input  logic             ovp_i,
   input  logic             zcd_i,
   output logic             gate_o,
   output logic [CNT_W-1:0] ton_o,
   output logic [CNT_W-1:0] tdm_o,
   output logic             cyc_vld_o,
   output logic [1:0]       flt_o
);
   localparam logic [CNT_W-1:0] PMIN_C = CNT_W'(PER_MIN_CYC);
   localparam logic [CNT_W-1:0] PMAX_C = CNT_W'(PER_MAX_CYC);
   localparam logic [CNT_W-1:0] TMIN_C = CNT_W'(TON_MIN_CYC);
   localparam logic [CNT_W-1:0] LEB_C  = CNT_W'(LEB_CYC);
   localparam logic [CNT_W-1:0] TMAX_C = CNT_W'(BUCK ? TON_MAX_BUCK : TON_MAX_FLY);

   generate
      if (TON_MIN_CYC < 1 || TON_MIN_CYC > TON_MAX_FLY || TON_MIN_CYC > TON_MAX_BUCK) begin : g_bad_ton
         $error("on-time floor must be positive and below both ceilings");
      end
      if (LEB_CYC >= TON_MAX_FLY || LEB_CYC >= TON_MAX_BUCK) begin : g_bad_leb
         $error("blanking must end before the on-time ceiling");
      end
      if (PER_MIN_CYC > PER_MAX_CYC || PER_MAX_CYC >= 2**CNT_W) begin : g_bad_per
         $error("period window does not fit the counter width");
      end
      if (TON_MAX_FLY >= PER_MAX_CYC || TON_MAX_BUCK >= PER_MAX_CYC) begin : g_bad_mix
         $error("on-time ceiling must be shorter than the longest period");
      end
   endgenerate

   qrg_state_e       state_q;
   qrg_flt_e         flt_q;
   logic [CNT_W-1:0] p_q;
   logic [CNT_W-1:0] p;
   logic [CNT_W-1:0] te;
   logic             gate_q;
   logic [CNT_W-1:0] ton_q;
   logic [CNT_W-1:0] tdm_q;
   logic             vld_q;

   logic [CNT_W-1:0] t_cur;
   logic             on_end;
   logic             ocp_f;
   logic             olp_f;
   logic [CNT_W-1:0] d_cur;
   logic             zc_ok;
   logic             ovp_f;
   logic             rs_done;

   qrg_on_timer #(
      .CW(CNT_W), .LEB_CYC(LEB_CYC), .TON_MIN_CYC(TON_MIN_CYC),
      .TON_MAX_FLY(TON_MAX_FLY), .TON_MAX_BUCK(TON_MAX_BUCK), .BUCK(BUCK)
   ) u_on (
      .clk_i(clk_i), .rst_i(rst_i), .act_i(state_q == ST_ON),
      .pk_i(pk_i), .ocp_i(ocp_i), .lvl_i(olp_lvl_i),
      .t_o(t_cur), .end_o(on_end), .ocp_flt_o(ocp_f), .olp_flt_o(olp_f)
   );

   qrg_demag_timer #(
      .CW(CNT_W), .ZBLK_LV(ZBLK_LV), .ZBLK_HV(ZBLK_HV), .HV(HV)
   ) u_dm (
      .clk_i(clk_i), .rst_i(rst_i), .act_i(state_q == ST_DEMAG),
      .zcd_i(zcd_i), .ovp_i(ovp_i),
      .d_o(d_cur), .zc_o(zc_ok), .ovp_flt_o(ovp_f)
   );

   qrg_restart_tmr #(
      .RESTART_CYC(RESTART_CYC)
   ) u_rs (
      .clk_i(clk_i), .rst_i(rst_i), .act_i(state_q == ST_FAULT), .done_o(rs_done)
   );

   assign p = p_q + CNT_W'(1);

   always_comb begin
      te = tgt_per_i;
      if (te < PMIN_C)      te = PMIN_C;
      else if (te > PMAX_C) te = PMAX_C;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_START;
         flt_q   <= FLT_NONE;
         p_q     <= '0;
         gate_q  <= 1'b0;
         ton_q   <= '0;
         tdm_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         p_q   <= (p >= PMAX_C) ? PMAX_C : p;
         case (state_q)
            ST_START: begin
               state_q <= ST_ON;
               gate_q  <= 1'b1;
               p_q     <= '0;
            end
            ST_ON: begin
               if (ocp_f || olp_f) begin
                  state_q <= ST_FAULT;
                  gate_q  <= 1'b0;
                  flt_q   <= ocp_f ? FLT_OCP : FLT_OLP;
               end else if (on_end) begin
                  state_q <= ST_DEMAG;
                  gate_q  <= 1'b0;
                  ton_q   <= t_cur;
               end
            end
            ST_DEMAG: begin
               if (ovp_f) begin
                  state_q <= ST_FAULT;
                  flt_q   <= FLT_OVP;
               end else if (zc_ok || p >= PMAX_C) begin
                  tdm_q <= d_cur;
                  if (p >= te) begin
                     state_q <= ST_ON;
                     gate_q  <= 1'b1;
                     p_q     <= '0;
                     vld_q   <= 1'b1;
                  end else begin
                     state_q <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if ((zcd_i && p >= te) || p >= PMAX_C) begin
                  state_q <= ST_ON;
                  gate_q  <= 1'b1;
                  p_q     <= '0;
                  vld_q   <= 1'b1;
               end
            end
            ST_FAULT: begin
               p_q <= '0;
               if (rs_done) begin
                  state_q <= ST_ON;
                  gate_q  <= 1'b1;
                  flt_q   <= FLT_NONE;
               end
            end
            default: state_q <= ST_START;
         endcase
      end
   end

   assign gate_o    = gate_q;
   assign ton_o     = ton_q;
   assign tdm_o     = tdm_q;
   assign cyc_vld_o = vld_q;
   assign flt_o     = flt_q;

   AST_TON_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(gate_o) && flt_o == 2'd0 |-> ton_o >= TMIN_C && ton_o <= TMAX_C); // R3
   AST_LEB_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(gate_o) && flt_o == 2'd0 && ton_o < TMAX_C |-> ton_o > LEB_C); // R2
   AST_PER_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
      cyc_vld_o |-> $past(p) >= PMIN_C && $past(p) <= PMAX_C); // R5
   AST_FLT_GATE_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      flt_o != 2'd0 |-> !gate_o); // R6
   AST_FLT_CODE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      flt_o != 2'd0 && $past(flt_o) != 2'd0 |-> flt_o == $past(flt_o)); // R9
   AST_VLD_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
      cyc_vld_o |-> $rose(gate_o)); // R10
endmodule

// File: tb/qr_gate_ctrl_tb_top.sv
module qr_gate_ctrl_tb_top;
   localparam int CW   = 17;
   localparam int LEB  = 3;
   localparam int TMIN = 4;
   localparam int TMXF = 20;
   localparam int TMXB = 30;
   localparam int PMIN = 40;
   localparam int PMAX = 200;
   localparam int ZLV  = 5;
   localparam int ZHV  = 7;
   localparam int RST  = 60;
   localparam int VP   = 7;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [CW-1:0] tgt;
   logic pk, ocp, olp, ovp, zcd;
   logic gate, vld;
   logic [CW-1:0] ton, tdm;
   logic [1:0] flt;

   logic gate_v, vld_v;
   logic [CW-1:0] ton_v, tdm_v;
   logic [1:0] flt_v;

   qr_gate_ctrl #(
      .CNT_W(CW), .LEB_CYC(LEB), .TON_MIN_CYC(TMIN), .TON_MAX_FLY(TMXF),
      .TON_MAX_BUCK(TMXB), .PER_MIN_CYC(PMIN), .PER_MAX_CYC(PMAX),
      .ZBLK_LV(ZLV), .ZBLK_HV(ZHV), .RESTART_CYC(RST), .BUCK(1'b0), .HV(1'b0)
   ) dut_i (
      .clk_i(clk), .rst_i(rst), .tgt_per_i(tgt), .pk_i(pk), .ocp_i(ocp),
      .olp_lvl_i(olp), .ovp_i(ovp), .zcd_i(zcd), .gate_o(gate), .ton_o(ton),
      .tdm_o(tdm), .cyc_vld_o(vld), .flt_o(flt)
   );

   qr_gate_ctrl #(
      .CNT_W(CW), .LEB_CYC(LEB), .TON_MIN_CYC(TMIN), .TON_MAX_FLY(TMXF),
      .TON_MAX_BUCK(TMXB), .PER_MIN_CYC(PMIN), .PER_MAX_CYC(PMAX),
      .ZBLK_LV(ZLV), .ZBLK_HV(ZHV), .RESTART_CYC(RST), .BUCK(1'b1), .HV(1'b1)
   ) dut_v (
      .clk_i(clk), .rst_i(rst), .tgt_per_i('0), .pk_i(1'b0), .ocp_i(1'b0),
      .olp_lvl_i(1'b1), .ovp_i(1'b0), .zcd_i(1'b1), .gate_o(gate_v), .ton_o(ton_v),
      .tdm_o(tdm_v), .cyc_vld_o(vld_v), .flt_o(flt_v)
   );

   int n_chk = 0;
   int n_err = 0;

   int pk_at = 8, zc_at = 9, ocp_at = 100, ovp_at = 100;
   bit ocp_en = 0, ovp_en = 0, olp_ok = 1;

   int hi_run = 0, lo_run = 0, since_rise = 0;
   int last_hi = 0, last_lo = 0, last_per = 0;
   bit wasg = 0;

   function automatic bit zf(int d, int z);
      return (d >= z) && (((d - z) % VP) == 0);
   endfunction

   // plant model and run-length monitor, evaluated at every falling edge
   initial begin
      pk = 0; ocp = 0; olp = 0; ovp = 0; zcd = 0; tgt = CW'(60);
      forever begin
         @(negedge clk);
         since_rise++;
         if (gate && !wasg) begin
            last_lo = lo_run; last_per = since_rise; since_rise = 0; hi_run = 0;
         end
         if (!gate && wasg) begin
            last_hi = hi_run; lo_run = 0;
         end
         if (gate) hi_run++; else lo_run++;
         pk  = gate && (hi_run >= pk_at);
         ocp = gate && ocp_en && (hi_run >= ocp_at);
         olp = gate && olp_ok;
         zcd = !gate && zf(lo_run, zc_at);
         ovp = !gate && ovp_en && (lo_run >= ovp_at);
         wasg = gate;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic wait_vld();
      do step(); while (!vld);
   endtask

   function automatic int clampi(int v, int lo, int hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   task automatic expect_cycle(input int pka, input int zca, input int tg,
                               output int e_ton, output int e_tdm, output int e_per);
      int m;
      int te;
      bit dm_done;
      m = pka;
      if (m < LEB + 1) m = LEB + 1;
      if (m < TMIN) m = TMIN;
      e_ton = (m > TMXF) ? TMXF : m;
      te = clampi(tg, PMIN, PMAX);
      dm_done = 0; e_tdm = 0; e_per = 0;
      for (int d = 1; d <= PMAX; d++) begin
         int p;
         p = e_ton + d;
         if (!dm_done) begin
            if (d > ZLV && zf(d, zca)) begin
               dm_done = 1; e_tdm = d;
               if (p >= te) begin e_per = p; break; end
            end else if (p >= PMAX) begin
               e_tdm = d; e_per = p; break;
            end
         end else if ((zf(d, zca) && p >= te) || p >= PMAX) begin
            e_per = p; break;
         end
      end
   endtask

   task automatic run_fault(input string tag, input int code, input int hi, input int lo);
      do step(); while (flt == 2'd0);
      chk({tag, " fault code"}, int'(flt), code);
      chk({tag, " gate low in fault"}, int'(gate), 0);
      chk({tag, " on-time before fault"}, last_hi, hi);
      ocp_en = 0; ovp_en = 0; olp_ok = 1; pk_at = 8;
      do step(); while (!gate);
      chk("R9 gate-low gap", last_lo, lo);
      chk("R9 code cleared on restart", int'(flt), 0);
      chk("R9 no strobe on restart", int'(vld), 0);
   endtask

   initial begin
      int e_ton, e_tdm, e_per;
      int tg_list[3];
      int zc_list[3];
      tg_list[0] = 10;  tg_list[1] = 60; tg_list[2] = 250;
      zc_list[0] = 2;   zc_list[1] = 9;  zc_list[2] = 250;

      repeat (4) step();
      chk("R1 gate in reset", int'(gate), 0);
      chk("R1 fault in reset", int'(flt), 0);
      chk("R1 strobe in reset", int'(vld), 0);
      rst = 1'b0;
      step();
      chk("R1 first gate rise", int'(gate), 1);

      do step(); while (!vld_v);
      chk("R3 buck ceiling", int'(ton_v), TMXB);
      chk("R4 high-line zcd blanking", int'(tdm_v), ZHV + 1);

      wait_vld();
      foreach (tg_list[i]) begin
         foreach (zc_list[j]) begin
            for (int k = 1; k <= 22; k++) begin
               pk_at = k; zc_at = zc_list[j]; tgt = CW'(tg_list[i]);
               expect_cycle(k, zc_list[j], tg_list[i], e_ton, e_tdm, e_per);
               wait_vld();
               chk("R2 R3 on-time", int'(ton), e_ton);
               chk("R4 discharge time", int'(tdm), e_tdm);
               chk("R5 period", last_per, e_per);
               chk("R10 strobe on first gate cycle", hi_run, 1);
            end
         end
      end

      pk_at = 8; zc_at = 9; tgt = CW'(60);
      pk_at = 10; ocp_en = 1; ocp_at = 6;
      run_fault("R6", 2, 6, RST);
      ocp_en = 1; ocp_at = 2; pk_at = 10;
      run_fault("R6 blanked", 2, LEB + 1, RST);
      olp_ok = 0; pk_at = 30;
      run_fault("R7", 3, TMXF, RST);
      ovp_en = 1; ovp_at = 3; pk_at = 5;
      run_fault("R8", 1, 5, ZLV + 1 + RST);

      wait_vld();
      chk("R9 normal cycle after restart", int'(ton), 8);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule